// File: doc/BRIEF.md
# Byte Serial Peripheral Interface Controller with Mode-Fault Detection

This block moves one byte at a time over a four-wire SPI link and can act either as the clock-driving master or as a select-gated slave. An eight-bit control register holds enable, bit order, role, clock polarity, clock phase, a two-bit clock rate and an interrupt enable. Writing a data byte starts a master transfer, or preloads the byte that a slave returns during its next transfer. Each finished byte raises a completion flag that software clears with a pulse; an interrupt line combines that flag with the interrupt enable and a chip-wide interrupt gate.

As a slave, the select input controls everything: while it is high the block ignores the link, and raising it in the middle of a byte throws the partial byte away. As a master whose select pin is set as an input, a low level on that pin means another master has claimed the bus. The block then clears its own master bit, releases SCK and MOSI, and raises the completion flag. It stays a slave until software writes the master bit to 1 again.

The shift engine is one state machine with four states. IDLE waits. On a start request it goes to MASTER_RUN; when a slave select arrives it goes to SLAVE_ARMED. MASTER_RUN leaves for DONE after its sixteenth clock edge. SLAVE_ARMED leaves for DONE after its sixteenth observed edge, and returns to IDLE when the select rises. DONE lasts one cycle and stores the received byte. From there a master goes back to IDLE, and a slave still selected goes back to SLAVE_ARMED with the next byte loaded. Disabling the block, a mode fault, or a software change of role sends any state to IDLE.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. A written value reads back unchanged through `cfg_rdata`, with bit 7 = interrupt enable, bit 6 = enable, bit 5 = bit order, bit 4 = master, bit 3 = clock polarity, bit 2 = clock phase, bits 1:0 = rate.
- R2: While the enable bit is 0, writing a data byte causes no SCK activity, no output enable and no completion flag, and slave traffic is ignored.
- R3: With bit order 0 the most significant bit goes out first. With bit order 1 the least significant bit goes out first.
- R4: A master transfer produces 8 SCK cycles, leaves SCK at its idle polarity, and raises `done_flag` with the received byte on `dat_rdata`. A `flag_ack` pulse clears the flag.
- R5: A master SCK half period lasts 2, 8, 32 or 64 system clocks for rate 0, 1, 2 or 3 (dividing the system clock by 4, 16, 64 and 128).
- R6: A master transfer looped back from MOSI to MISO returns the sent byte in all four combinations of clock polarity and clock phase. Phase 0 samples on the leading edge; phase 1 samples on the trailing edge.
- R7: A slave with select low receives the byte shifted in on MOSI and returns its preloaded byte on MISO. `miso_oe` is high only while the slave is selected and `miso_en` is high.
- R8: Raising the select in slave mode during a byte discards the partial byte without a completion. The next byte is received whole.
- R9: A slave whose select is high ignores SCK and MOSI edges and keeps `miso_oe` low.
- R10: In master mode with `sel_dir` = 0, a low select clears the master bit, raises `done_flag`, and drops `sck_oe` and `mosi_oe`.
- R11: In master mode with `sel_dir` = 1, the select input has no effect, and transfers complete normally while it is low.
- R12: After a mode fault the master bit stays 0 until software writes it to 1.
- R13: `irq` is high exactly when `done_flag`, the interrupt enable bit and `glb_ie` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| dat_wr | input | 1 | Data byte write strobe (starts master transfer / preloads slave byte) |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rdata | output | 8 | Last received byte |
| flag_ack | input | 1 | Clears the completion flag |
| done_flag | output | 1 | Transfer complete or mode fault |
| glb_ie | input | 1 | Chip-wide interrupt gate |
| irq | output | 1 | Interrupt request |
| sel_dir | input | 1 | Master-mode select pin direction: 1 output, 0 input |
| miso_en | input | 1 | User enable for driving MISO as a slave |
| sel_in | input | 1 | Select pin level |
| sck_in | input | 1 | SCK pin level |
| mosi_in | input | 1 | MOSI pin level |
| miso_in | input | 1 | MISO pin level |
| sck_out | output | 1 | SCK drive value |
| sck_oe | output | 1 | SCK output enable |
| mosi_out | output | 1 | MOSI drive value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_out | output | 1 | MISO drive value |
| miso_oe | output | 1 | MISO output enable |

## Verification
The hardest conditions to reach are the two aborts: a slave select that rises partway through a byte, and a competing master that pulls the select low while this block is master. The bench plays the external master bit by bit, so it can release the select after five edges and then send a full byte. The scoreboard confirms that only the whole byte completes. For the fault, the bench puts the block in master mode with the select set as an input, drives the select low, and then checks the cleared master bit, the flag, the interrupt, and the released pins. It also checks that the master bit stays clear until it is rewritten.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MRUN,
        ST_SARM,
        ST_DONE
    } eng_st_t;

    localparam int F_IE   = 7;
    localparam int F_EN   = 6;
    localparam int F_ORD  = 5;
    localparam int F_MST  = 4;
    localparam int F_CPOL = 3;
    localparam int F_CPHA = 2;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int          W   = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic hold;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= RST[i];
                hold <= RST[i];
            end else begin
                meta <= d[i];
                hold <= meta;
            end
        end
        assign q[i] = hold;
    end
endmodule

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
    parameter int BASE_HALF = 2,
    parameter int CNT_W     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    always_comb begin
        unique case (rate)
            2'd0: half = CNT_W'(BASE_HALF);
            2'd1: half = CNT_W'(BASE_HALF << 2);
            2'd2: half = CNT_W'(BASE_HALF << 4);
            2'd3: half = CNT_W'(BASE_HALF << 5);
        endcase
    end

    assign tick = run && (cnt == half - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                  cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int OC_W  = $clog2(DATA_W),
    localparam int EC_W  = $clog2(2 * DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              is_mst,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              dord,
    input  logic              go,
    input  logic              tick,
    input  logic              slv_act,
    input  logic              slv_sck,
    input  logic              sin,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sout,
    output logic              sck_gen,
    output logic              idle,
    output logic              mrun,
    output logic              done_q,
    output logic [DATA_W-1:0] rx_byte
);
    localparam logic [EC_W-1:0] LAST_E = EC_W'(2 * DATA_W - 1);

    eng_st_t           st, nxt;
    logic [EC_W-1:0]   ecnt;
    logic [OC_W-1:0]   ocnt;
    logic [DATA_W-1:0] tx_sh, rx_sh, rx_nx;
    logic              sck_prev, sck_lvl;
    logic              edge_ev, last, sample, adv;

    always_comb begin
        unique case (st)
            ST_MRUN: edge_ev = tick;
            ST_SARM: edge_ev = (slv_sck != sck_prev);
            default: edge_ev = 1'b0;
        endcase
        last   = edge_ev && (ecnt == LAST_E);
        sample = (~ecnt[0]) ^ cpha;
        adv    = !sample && !(cpha && ecnt == '0);
        rx_nx  = dord ? {sin, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], sin};
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (go) nxt = ST_MRUN;
                     else if (slv_act) nxt = ST_SARM;
            ST_MRUN: if (last) nxt = ST_DONE;
            ST_SARM: if (!slv_act) nxt = ST_IDLE;
                     else if (last) nxt = ST_DONE;
            ST_DONE: nxt = (!is_mst && slv_act) ? ST_SARM : ST_IDLE;
        endcase
        if (abort) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt     <= '0;
            ocnt     <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            sck_prev <= 1'b0;
            sck_lvl  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            sck_prev <= slv_sck;
            done_q   <= (st == ST_DONE) && !abort;
            if (st == ST_DONE) rx_byte <= rx_sh;
            if (abort || (st == ST_SARM && !slv_act)) begin
                ecnt    <= '0;
                ocnt    <= '0;
                sck_lvl <= 1'b0;
            end else if ((st == ST_IDLE && nxt != ST_IDLE) || st == ST_DONE) begin
                tx_sh   <= tx_byte;
                ecnt    <= '0;
                ocnt    <= '0;
                sck_lvl <= 1'b0;
            end else if (edge_ev) begin
                ecnt    <= ecnt + EC_W'(1);
                sck_lvl <= ~sck_lvl;
                if (sample) rx_sh <= rx_nx;
                if (adv)    ocnt  <= ocnt + OC_W'(1);
            end
        end
    end

    assign sout    = dord ? tx_sh[ocnt] : tx_sh[OC_W'(DATA_W - 1) - ocnt];
    assign sck_gen = cpol ^ sck_lvl;
    assign idle    = (st == ST_IDLE);
    assign mrun    = (st == ST_MRUN);

    // R4: a byte never takes more than 2*DATA_W edges
    a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt <= EC_W'(2 * DATA_W));

    // R8: a select release while armed discards the byte in progress
    a_r8_slave_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SARM && !slv_act && !abort) |=> (st == ST_IDLE && ecnt == '0));

    // R4: the completion pulse follows the DONE state by one cycle
    a_r4_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(st == ST_DONE));
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
    import spi_port_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BASE_HALF = 2,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic [DATA_W-1:0] dat_rdata,
    input  logic              flag_ack,
    output logic              done_flag,
    input  logic              glb_ie,
    output logic              irq,
    input  logic              sel_dir,
    input  logic              miso_en,
    input  logic              sel_in,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              miso_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              mosi_out,
    output logic              mosi_oe,
    output logic              miso_out,
    output logic              miso_oe
);
    logic [7:0]        ctrl;
    logic [2:0]        pin_s;
    logic              sel_s, sck_s, mosi_s;
    logic              en, mst, fault, role_chg, abort;
    logic              slv_act, go, eng_idle, eng_mrun, done_q, tick;
    logic              sout, sck_gen, flag;
    logic [DATA_W-1:0] txbuf, tx_byte;

    spi_port_sync #(.W(3), .RST(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sel_in, sck_in, mosi_in}), .q(pin_s)
    );
    assign {sel_s, sck_s, mosi_s} = pin_s;

    assign en       = ctrl[F_EN];
    assign mst      = ctrl[F_MST];
    assign fault    = en && mst && !sel_dir && !sel_s;
    assign role_chg = cfg_wr && (cfg_wdata[F_MST] != mst);
    assign abort    = !en || fault || role_chg;
    assign slv_act  = en && !mst && !sel_s;
    assign go       = dat_wr && en && mst && eng_idle && !abort;
    assign tx_byte  = dat_wr ? dat_wdata : txbuf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= '0;
            flag  <= 1'b0;
            txbuf <= '0;
        end else begin
            if (cfg_wr) ctrl <= cfg_wdata;
            if (fault)  ctrl[F_MST] <= 1'b0;
            if (done_q || fault) flag <= 1'b1;
            else if (flag_ack)   flag <= 1'b0;
            if (dat_wr && en) txbuf <= dat_wdata;
        end
    end

    spi_port_clkdiv #(.BASE_HALF(BASE_HALF), .CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_mrun),
        .rate(ctrl[1:0]), .tick(tick)
    );

    spi_port_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .abort(abort), .is_mst(mst),
        .cpol(ctrl[F_CPOL]), .cpha(ctrl[F_CPHA]), .dord(ctrl[F_ORD]),
        .go(go), .tick(tick), .slv_act(slv_act), .slv_sck(sck_s),
        .sin(mst ? miso_in : mosi_s), .tx_byte(tx_byte),
        .sout(sout), .sck_gen(sck_gen), .idle(eng_idle), .mrun(eng_mrun),
        .done_q(done_q), .rx_byte(dat_rdata)
    );

    assign cfg_rdata = ctrl;
    assign done_flag = flag;
    assign irq       = flag && ctrl[F_IE] && glb_ie;
    assign sck_oe    = en && mst;
    assign mosi_oe   = en && mst;
    assign sck_out   = (en && mst) ? sck_gen : 1'b0;
    assign mosi_out  = sout;
    assign miso_out  = sout;
    assign miso_oe   = slv_act && miso_en;

    // R10: a mode fault drops the master bit and raises the flag
    a_r10_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!ctrl[F_MST] && flag));

    // R12: the master bit stays clear until software rewrites it
    a_r12_mst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[F_MST] && !cfg_wr) |=> !ctrl[F_MST]);

    // R2: with the enable bit low the engine sits in IDLE
    a_r2_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> eng_idle);

    // R4: every completion pulse leaves the flag set
    a_r4_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> flag);
endmodule

// File: tb/sim_spi_port_ctrl.sv
module sim_spi_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, dat_wr = 1'b0, flag_ack = 1'b0;
    logic [7:0] cfg_wdata = '0, dat_wdata = '0;
    logic [7:0] cfg_rdata, dat_rdata;
    logic       done_flag, irq, glb_ie = 1'b0;
    logic       sel_dir = 1'b1, miso_en = 1'b1;
    logic       sel_in = 1'b1, sck_in = 1'b0, mosi_in = 1'b0, miso_in;
    logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

    int tests = 0, fails = 0;
    logic [7:0] exp_q[$];
    logic       flag_d = 1'b0;
    logic       cap_en = 1'b0;
    logic [7:0] cap = '0;

    always #2 clk = ~clk;

    assign miso_in = mosi_out;

    spi_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .dat_rdata(dat_rdata), .flag_ack(flag_ack), .done_flag(done_flag),
        .glb_ie(glb_ie), .irq(irq), .sel_dir(sel_dir), .miso_en(miso_en),
        .sel_in(sel_in), .sck_in(sck_in), .mosi_in(mosi_in), .miso_in(miso_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: each rising completion flag pops one expected byte
    always @(negedge clk) begin
        if (done_flag && !flag_d && exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(dat_rdata == e, "R4/R6/R7 received byte", dat_rdata, e);
        end
        flag_d = done_flag;
    end

    always @(posedge sck_out) if (cap_en) cap = {cap[6:0], mosi_out};

    task automatic cfg(input logic [7:0] v);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_wdata = v; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk) flag_ack = 1'b1;
        @(negedge clk) flag_ack = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk) begin dat_wr = 1'b1; dat_wdata = b; end
        @(negedge clk) dat_wr = 1'b0;
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 4000 && !done_flag; i++) @(negedge clk);
    endtask

    task automatic m_xfer(input logic [7:0] b);
        exp_q.push_back(b);
        put(b);
        wait_flag();
        chk(done_flag, "R4 completion", done_flag, 1);
        @(negedge clk);
        ack();
    endtask

    task automatic hwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bench acts as external master; returns byte seen on MISO
    task automatic s_xfer(input logic [7:0] b, input int nbits, input bit cpol,
                          input bit cpha, input bit dord, output logic [7:0] got);
        got = '0;
        sck_in = cpol;
        sel_in = 1'b0;
        hwait(10);
        for (int i = 0; i < nbits; i++) begin
            int k;
            k = dord ? i : 7 - i;
            if (!cpha) begin
                mosi_in = b[k]; hwait(10);
                got[k] = miso_out; sck_in = ~sck_in; hwait(10);
                sck_in = ~sck_in;
            end else begin
                sck_in = ~sck_in; mosi_in = b[k]; hwait(10);
                got[k] = miso_out; sck_in = ~sck_in; hwait(10);
            end
        end
        hwait(10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] got;
        hwait(3);
        rst_n = 1'b1;
        hwait(2);
        chk(cfg_rdata == 8'h00, "R1 reset value", cfg_rdata, 0);
        chk(!done_flag && !irq && !sck_oe && !miso_oe, "R1 reset outputs", {done_flag, irq, sck_oe, miso_oe}, 0);
        cfg(8'hA7);
        hwait(1);
        chk(cfg_rdata == 8'hA7, "R1 readback", cfg_rdata, 8'hA7);

        // R2: disabled master does nothing
        cfg(8'h10);
        put(8'h81);
        hwait(400);
        chk(!done_flag && !sck_oe && !mosi_oe && sck_out == 1'b0, "R2 disabled master", {done_flag, sck_oe}, 0);

        // R6: loopback in all four clock modes (R4 on each)
        for (int m = 0; m < 4; m++) begin
            cfg(8'h50 | 8'(m << 2));
            m_xfer(8'hA5 ^ 8'(m * 37));
            chk(sck_out == m[1], "R4 sck idle level", sck_out, m[1]);
        end
        chk(!done_flag, "R4 flag cleared by ack", done_flag, 0);

        // R3: bit order on MOSI (mode 0, leading edges rising)
        cfg(8'h50);
        cap_en = 1'b1; m_xfer(8'hC1); cap_en = 1'b0;
        chk(cap == 8'hC1, "R3 msb first", cap, 8'hC1);
        cfg(8'h70);
        cap_en = 1'b1; m_xfer(8'hC1); cap_en = 1'b0;
        chk(cap == 8'h83, "R3 lsb first", cap, 8'h83);

        // R5: half period per rate
        for (int r = 0; r < 4; r++) begin
            int n, e;
            logic s0;
            e = (r == 3) ? 64 : (2 << (2 * r));
            cfg(8'h50 | 8'(r));
            exp_q.push_back(8'h3E);
            put(8'h3E);
            s0 = sck_out;
            for (int i = 0; i < 300 && sck_out == s0; i++) @(negedge clk);
            n = 0;
            s0 = sck_out;
            while (sck_out == s0 && n < 300) begin @(negedge clk); n++; end
            chk(n == e, "R5 half period", n, e);
            wait_flag();
            @(negedge clk);
            ack();
        end

        // R7: slave receive and transmit, two modes
        cfg(8'h40);
        put(8'h3C);
        exp_q.push_back(8'h96);
        fork
            begin hwait(15); chk(miso_oe, "R7 miso_oe while selected", miso_oe, 1); end
            s_xfer(8'h96, 8, 1'b0, 1'b0, 1'b0, got);
        join
        chk(got == 8'h3C, "R7 miso byte mode0", got, 8'h3C);
        chk(done_flag, "R7 slave completion", done_flag, 1);
        sel_in = 1'b1; hwait(5);
        chk(!miso_oe, "R7 miso_oe released", miso_oe, 0);
        ack();
        cfg(8'h6C);
        put(8'h5B);
        exp_q.push_back(8'hE2);
        s_xfer(8'hE2, 8, 1'b1, 1'b1, 1'b1, got);
        chk(got == 8'h5B, "R7 miso byte mode3 lsb", got, 8'h5B);
        sel_in = 1'b1; hwait(5);
        ack();

        // R9: edges with select high are ignored
        cfg(8'h40);
        put(8'h00);
        for (int i = 0; i < 16; i++) begin sck_in = ~sck_in; mosi_in = i[0]; hwait(10); end
        chk(!done_flag && !miso_oe, "R9 passive slave", {done_flag, miso_oe}, 0);
        exp_q.push_back(8'h4D);
        s_xfer(8'h4D, 8, 1'b0, 1'b0, 1'b0, got);
        sel_in = 1'b1; hwait(5);
        chk(exp_q.size() == 0, "R9 later byte intact", exp_q.size(), 0);
        ack();

        // R8: partial byte dropped on select release
        s_xfer(8'hFF, 5, 1'b0, 1'b0, 1'b0, got);
        sel_in = 1'b1; hwait(8);
        chk(!done_flag, "R8 no completion on partial", done_flag, 0);
        exp_q.push_back(8'h5A);
        s_xfer(8'h5A, 8, 1'b0, 1'b0, 1'b0, got);
        sel_in = 1'b1; hwait(5);
        chk(exp_q.size() == 0, "R8 full byte after abort", exp_q.size(), 0);
        ack();

        // R11: select as output, low select has no effect
        sel_dir = 1'b1;
        cfg(8'h50);
        sel_in = 1'b0; hwait(6);
        chk(cfg_rdata[4] && !done_flag, "R11 select output ignored", cfg_rdata, 8'h50);
        m_xfer(8'h27);
        sel_in = 1'b1; hwait(4);

        // R10 / R12 / R13: mode fault
        sel_dir = 1'b0;
        glb_ie = 1'b1;
        cfg(8'hD0);
        hwait(4);
        chk(!done_flag && !irq, "R13 irq low without flag", irq, 0);
        sel_in = 1'b0; hwait(6);
        chk(cfg_rdata == 8'hC0, "R10 master bit cleared", cfg_rdata, 8'hC0);
        chk(done_flag, "R10 flag raised", done_flag, 1);
        chk(!sck_oe && !mosi_oe, "R10 pins released", {sck_oe, mosi_oe}, 0);
        chk(irq, "R13 irq asserted", irq, 1);
        glb_ie = 1'b0; hwait(1);
        chk(!irq, "R13 irq gated by glb_ie", irq, 0);
        glb_ie = 1'b1;
        sel_in = 1'b1; hwait(20);
        chk(!cfg_rdata[4], "R12 master stays cleared", cfg_rdata, 8'hC0);
        ack();
        cfg(8'hD0);
        hwait(4);
        chk(cfg_rdata[4] && sck_oe, "R12 master restored by write", cfg_rdata, 8'hD0);
        m_xfer(8'h6E);
        chk(!irq, "R13 irq drops after ack", irq, 0);

        hwait(5);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule